// File: doc/BRIEF.md
# Overload Fault and Restart Sequencer

This block is the protection state machine of an off-line switching controller. It tells a brief overcurrent during start-up or a load step apart from a real overload. It supervises the supply during a latched fault and schedules restart attempts. All analog decisions arrive as single-bit flags that comparators have already produced. These cover the peak-current limit, the over-voltage trip level on the sense pin, and the supply relative to its turn-on, undervoltage, latch-off floor and deep-reset levels. A thermal flag comes in the same way. The block drives the gate enable, the high-voltage start-up current source, a one-cycle soft-start restart pulse and a fault indication.

A peak-current error that lasts a configurable number of clock cycles is treated as a real overload. An undervoltage while running is acted on at once. Either event starts a coasting phase with the start-up source off. When the supply reaches the floor, the source recharges it until the turn-on level. Only every second completed recharge lets the drive restart, which halves the fault duty. An over-voltage trip seen during the gate's off time, or a thermal trip, locks the block off until the supply falls through the deep-reset level.

Top module: `overload_sequencer`

## Requirements
- R1: After reset the drive is off, the start-up source is on, the fault output is low and no soft-start pulse is given. The first time the turn-on flag is sampled high, the drive turns on one cycle later and no divider is applied.
- R2: If the error flag is sampled high in `CONFIRM_CYCLES` consecutive cycles while running, the drive turns off and the fault output rises in the next cycle.
- R3: A single cycle with the error flag low while running clears the confirmation count, so the drive stays on until a fresh run of `CONFIRM_CYCLES` high samples.
- R4: The undervoltage flag sampled high while running turns the drive off in the next cycle, without waiting for the confirmation timer.
- R5: After a fault the block coasts with the drive and the source off and the fault output high. The floor flag switches the source on, and the turn-on flag switches it off again. The drive and the source are never on together.
- R6: The first completed recharge after a fault returns to coasting with the drive off. The second completed recharge restarts the drive.
- R7: Every transition into running, including the first after reset, raises `ss_restart` for exactly one cycle, in the same cycle the drive turns on.
- R8: The over-voltage flag sampled high while `gate_on` is low locks the block off: drive and source off, fault high. While `gate_on` is high the flag has no effect.
- R9: The thermal flag sampled high locks the block off in the same way as R8.
- R10: While locked, the floor and turn-on flags have no effect. Only the deep-reset flag releases the lock.
- R11: The deep-reset flag, from any state, returns the block to the start-up state with the timer and the restart divider cleared. It has priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_flag | input | 1 | Peak-current limit reached |
| ovp_level | input | 1 | Sense pin above the over-voltage trip level |
| gate_on | input | 1 | Present state of the PWM gate (high during on time) |
| vcc_on | input | 1 | Supply above the turn-on level |
| vcc_uvlo | input | 1 | Supply below the undervoltage level |
| vcc_floor | input | 1 | Supply below the latch-off floor |
| vcc_reset | input | 1 | Supply below the deep-reset level |
| thermal | input | 1 | Thermal shutdown flag |
| drive_en | output | 1 | Gate drive permitted |
| hv_src_en | output | 1 | High-voltage start-up current source on |
| ss_restart | output | 1 | One-cycle pulse that restarts soft-start |
| fault | output | 1 | Block is coasting, recharging or locked |

## Verification
The bench first holds the error flag high for one cycle less than the confirmation window, then drops it for a single cycle. A design that did not clear its count would then trip early, and one that tripped a cycle late would keep the drive on past the window. A divider that was off by one would restart after the first recharge, or need three. Stale divider state left over from a deep reset in mid-sequence would delay the next power-up. The over-voltage flag is raised during the gate's on time, where a design that did not gate it would lock up. Recharge flags are pulsed while locked, where a design that left the lock would restart without a deep reset.

// File: rtl/overload_sequencer.sv
module overload_sequencer #(
  parameter int unsigned CONFIRM_CYCLES = 15_625_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_flag,
  input  logic ovp_level,
  input  logic gate_on,
  input  logic vcc_on,
  input  logic vcc_uvlo,
  input  logic vcc_floor,
  input  logic vcc_reset,
  input  logic thermal,
  output logic drive_en,
  output logic hv_src_en,
  output logic ss_restart,
  output logic fault
);
  localparam int TW = $clog2(CONFIRM_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(CONFIRM_CYCLES - 1);

  typedef enum logic [2:0] {S_BOOT, S_RUN, S_COAST, S_RECHG, S_LOCK} st_t;

  st_t           state;
  logic [TW-1:0] tmr;
  logic          second;
  logic          trip_ovp;

  assign trip_ovp = ovp_level && !gate_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_BOOT;
      tmr        <= '0;
      second     <= 1'b0;
      ss_restart <= 1'b0;
    end else begin
      ss_restart <= 1'b0;
      if (vcc_reset) begin
        state  <= S_BOOT;
        tmr    <= '0;
        second <= 1'b0;
      end else if (thermal || trip_ovp) begin
        state <= S_LOCK;
        tmr   <= '0;
      end else begin
        case (state)
          S_BOOT:
            if (vcc_on) begin
              state      <= S_RUN;
              ss_restart <= 1'b1;
            end
          S_RUN:
            if (vcc_uvlo) begin
              state  <= S_COAST;
              tmr    <= '0;
              second <= 1'b0;
            end else if (err_flag) begin
              if (tmr == LAST) begin
                state  <= S_COAST;
                tmr    <= '0;
                second <= 1'b0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end else begin
              tmr <= '0;
            end
          S_COAST:
            if (vcc_floor) state <= S_RECHG;
          S_RECHG:
            if (vcc_on) begin
              if (second) begin
                state      <= S_RUN;
                ss_restart <= 1'b1;
                second     <= 1'b0;
              end else begin
                state  <= S_COAST;
                second <= 1'b1;
              end
            end
          default: ;
        endcase
      end
    end
  end

  assign drive_en  = (state == S_RUN);
  assign hv_src_en = (state == S_BOOT) || (state == S_RECHG);
  assign fault     = (state == S_COAST) || (state == S_RECHG) || (state == S_LOCK);
endmodule

// File: rtl/overload_sequencer_chk.sv
module overload_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic err_flag,
  input logic ovp_level,
  input logic gate_on,
  input logic vcc_on,
  input logic vcc_uvlo,
  input logic vcc_floor,
  input logic vcc_reset,
  input logic thermal,
  input logic drive_en,
  input logic hv_src_en,
  input logic ss_restart,
  input logic fault
);
  assert_uvlo_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && vcc_uvlo && !vcc_reset) |=> !drive_en);

  assert_not_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && hv_src_en));

  assert_pulse_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> ss_restart);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |=> !ss_restart);

  assert_ovp_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_level && !gate_on && !vcc_reset) |=> (fault && !drive_en && !hv_src_en));

  assert_thermal_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thermal && !vcc_reset) |=> (fault && !drive_en && !hv_src_en));

  assert_deep_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_reset |=> (!drive_en && !fault && hv_src_en));
endmodule

bind overload_sequencer overload_sequencer_chk u_chk (.*);

// File: tb/overload_sequencer_test.sv
module overload_sequencer_test;
  localparam int CONF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_flag = 0, ovp_level = 0, gate_on = 0, vcc_on = 0;
  logic vcc_uvlo = 0, vcc_floor = 0, vcc_reset = 0, thermal = 0;
  logic drive_en, hv_src_en, ss_restart, fault;

  always #4 clk = ~clk;

  overload_sequencer #(.CONFIRM_CYCLES(CONF)) uut (
    .clk(clk), .rst_n(rst_n), .err_flag(err_flag), .ovp_level(ovp_level),
    .gate_on(gate_on), .vcc_on(vcc_on), .vcc_uvlo(vcc_uvlo),
    .vcc_floor(vcc_floor), .vcc_reset(vcc_reset), .thermal(thermal),
    .drive_en(drive_en), .hv_src_en(hv_src_en), .ss_restart(ss_restart),
    .fault(fault));

  int checks = 0, errors = 0, cycles = 0;
  string req = "R1";
  bit done = 0;

  // reference: 0 boot, 1 run, 2 coast, 3 recharge, 4 locked
  int m_mode = 0, m_run = 0, m_starts = 0;
  bit m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_starts = 0; m_pulse = 0;
    end else begin
      m_pulse = 0;
      if (vcc_reset) begin
        m_mode = 0; m_run = 0; m_starts = 0;
      end else if (thermal || (ovp_level && !gate_on)) begin
        m_mode = 4; m_run = 0;
      end else if (m_mode == 0) begin
        if (vcc_on) begin m_mode = 1; m_pulse = 1; end
      end else if (m_mode == 1) begin
        m_run = err_flag ? m_run + 1 : 0;
        if (vcc_uvlo || m_run >= CONF) begin
          m_mode = 2; m_run = 0; m_starts = 0;
        end
      end else if (m_mode == 2) begin
        if (vcc_floor) m_mode = 3;
      end else if (m_mode == 3) begin
        if (vcc_on) begin
          m_starts++;
          if (m_starts == 2) begin m_mode = 1; m_pulse = 1; m_starts = 0; end
          else m_mode = 2;
        end
      end
    end
  end

  task automatic cmp(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%b expected=%b at cycle %0d", req, name, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      cmp("drive_en",   drive_en,   m_mode == 1);
      cmp("hv_src_en",  hv_src_en,  m_mode == 0 || m_mode == 3);
      cmp("fault",      fault,      m_mode >= 2);
      cmp("ss_restart", ss_restart, m_pulse);
    end
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic recharge_pair();
    vcc_floor = 1; step(1); vcc_floor = 0; step(3);
    vcc_on = 1; step(1); vcc_on = 0; step(3);
    vcc_floor = 1; step(1); vcc_floor = 0; step(3);
    vcc_on = 1; step(1); vcc_on = 0; step(3);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    req = "R1"; step(3);
    vcc_on = 1; step(1); vcc_on = 0;
    req = "R7"; step(3);
    req = "R3";
    err_flag = 1; step(CONF - 1); err_flag = 0; step(1);
    err_flag = 1; step(CONF - 1); err_flag = 0; step(3);
    req = "R2";
    err_flag = 1; step(CONF + 5); err_flag = 0; step(3);
    req = "R5"; step(2);
    vcc_floor = 1; step(1); vcc_floor = 0; step(3);
    req = "R6";
    vcc_on = 1; step(1); vcc_on = 0; step(3);
    vcc_floor = 1; step(1); vcc_floor = 0; step(3);
    req = "R7";
    vcc_on = 1; step(1); vcc_on = 0; step(3);
    req = "R4";
    err_flag = 1; step(5);
    vcc_uvlo = 1; step(1); vcc_uvlo = 0; err_flag = 0; step(3);
    recharge_pair();
    req = "R8";
    gate_on = 1; ovp_level = 1; step(4); ovp_level = 0; gate_on = 0; step(2);
    ovp_level = 1; step(1); ovp_level = 0; step(3);
    req = "R10";
    recharge_pair();
    vcc_uvlo = 1; step(2); vcc_uvlo = 0; step(2);
    req = "R11";
    vcc_reset = 1; step(2); vcc_reset = 0; step(2);
    vcc_on = 1; step(1); vcc_on = 0; step(3);
    req = "R9";
    thermal = 1; step(1); thermal = 0; step(3);
    vcc_floor = 1; step(1); vcc_floor = 0; step(2);
    req = "R11";
    vcc_reset = 1; step(1); vcc_reset = 0; step(2);
    vcc_on = 1; step(1); vcc_on = 0; step(3);
    vcc_uvlo = 1; step(1); vcc_uvlo = 0; step(2);
    vcc_floor = 1; step(1); vcc_floor = 0; step(2);
    vcc_on = 1; step(1); vcc_on = 0; step(2);
    vcc_floor = 1; step(1); vcc_floor = 0; step(2);
    vcc_reset = 1; step(1); vcc_reset = 0; step(2);
    vcc_on = 1; step(1); vcc_on = 0; step(3);
    vcc_reset = 1; step(1); vcc_reset = 0; step(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule